// File: doc/BRIEF.md
# Chunked Spare-Buffer Address Mapper

This block turns one linear byte access to a NAND page image into a stream of addresses for an on-chip buffer memory. The main part of the page sits linearly from address 0. The out-of-band (spare) bytes are not stored linearly. They are spread over up to eight fixed 64-byte spare buffers starting at address 0x1000, one buffer per 512-byte chunk of the page.

A requester gives the page-size code, the spare size, a start column, a byte count, a write flag and a spare-only flag. It then pulses `start`. After a fixed setup phase, the block presents one buffer address per cycle on a valid/ready byte handshake. An access that runs off the end of the main area continues at the start of the spare area. When the walk ends, the block pulses `done`. An access that cannot be mapped is refused: `done` and `err` are raised together, and no bytes are presented.

Top module: `oob_addr_mapper`

## Requirements
- R1: During and after reset, with no start accepted, `busy`, `byte_valid`, `done` and `err` are low.
- R2: `start` is taken only while `busy` is low. A `start` pulse while busy does not change the address sequence, the byte count or the cycle of `done` of the access in progress.
- R3: The first byte is presented in the cycle after the 7th rising edge that follows the accepting edge. With `byte_ready` high, each following byte is presented one cycle later. A main-area byte at column c gets `buf_addr` = c.
- R4: `page_sel` selects the page size: 00 = 512, 01 = 2048, 10 = 4096 bytes. The chunk count is the page size / 512. The per-buffer size is spare_size / chunks, rounded down to an even number. For spare offset f, the index is s = min(f / size, 7), and `buf_addr` = 0x1000 + 64·s + (f − s·size). Bytes past the last whole share therefore stay in a higher buffer, and buffer 7 absorbs everything from index 7 on.
- R5: With `spare_only` low, a column at or above the page size is spare offset column − page size. With `spare_only` high, every column is taken as a spare offset.
- R6: An access that starts in the main area and reaches the page end continues with spare offset 0 on the next byte.
- R7: A presented byte keeps its address and write enable until a cycle with `byte_ready` high. `buf_we` equals the write flag captured at start while `byte_valid` is high, and is 0 otherwise.
- R8: `done` is high for exactly one cycle: the cycle after the edge that accepts the last byte, or the 8th cycle after acceptance for a zero-length access. `busy` is low in the cycle after `done`.
- R9: The start is refused if any of these holds: page code 11; per-buffer size below 2 or above 64; column + length beyond the page size + spare size (beyond the spare size alone in spare-only mode). A refused start raises `done` and `err` together in the cycle after acceptance, with no byte presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new access (taken while idle) |
| wr | input | 1 | 1 = write access, 0 = read access |
| spare_only | input | 1 | Treat columns as spare offsets |
| page_sel | input | 2 | Page size code |
| spare_size | input | 8 | Spare bytes per page |
| column | input | 13 | Start column |
| length | input | 13 | Byte count |
| byte_ready | input | 1 | Consumer takes the presented byte |
| busy | output | 1 | An access is in progress |
| byte_valid | output | 1 | A byte address is presented |
| buf_addr | output | 13 | Buffer memory byte address |
| buf_we | output | 1 | Write enable for the presented byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access refused, valid with `done` |

## Verification
The result times are fixed by the state registers. A refusal shows up in the cycle after the accepting edge. The first byte follows exactly seven more edges, and each later byte follows one edge after a cycle with `byte_ready` high. `done` arrives one edge after the last accepted byte, and idle follows one edge after that. The bench drives inputs on falling edges and samples on the falling edge where each result is due: it counts seven falling edges after acceptance, then steps one edge per handshake. A stall or an ignored start is therefore seen as an address that did not move, or a `done` that came at the wrong edge.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } sbm_state_e;

  // log2 of chunks per page for each page code
  function automatic logic [1:0] chunk_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   chunk_shift = 2'd0;
      2'b01:   chunk_shift = 2'd2;
      default: chunk_shift = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/sbm_geom.sv
module sbm_geom
  import sbm_pkg::*;
#(
  parameter int COL_W       = 13,
  parameter int SPARE_W     = 8,
  parameter int SBUF_BYTES  = 64,
  parameter int CHUNK_BYTES = 512,
  localparam int OFF_W      = SPARE_W + 1
) (
  input  logic [1:0]         page_sel,
  input  logic [SPARE_W-1:0] spare_size,
  input  logic [COL_W-1:0]   column,
  input  logic [COL_W-1:0]   length,
  input  logic               spare_only,
  output logic [COL_W-1:0]   page_bytes,
  output logic [SPARE_W-1:0] share_bytes,
  output logic [OFF_W-1:0]   spare_off,
  output logic               start_main,
  output logic               cfg_err
);

  logic [1:0]     shift;
  logic [COL_W:0] end_pos;
  logic [COL_W:0] limit;
  logic [COL_W-1:0] off_full;

  always_comb begin
    shift       = chunk_shift(page_sel);
    page_bytes  = COL_W'(CHUNK_BYTES) << shift;
    share_bytes = (spare_size >> shift) & ~SPARE_W'(1);
    end_pos     = {1'b0, column} + {1'b0, length};
    limit       = spare_only ? (COL_W+1)'(spare_size)
                             : {1'b0, page_bytes} + (COL_W+1)'(spare_size);
    start_main  = !spare_only && (column < page_bytes);
    off_full    = spare_only ? column : (column - page_bytes);
    spare_off   = OFF_W'(off_full);
    cfg_err     = (page_sel == 2'b11)
               || (int'(share_bytes) < 2)
               || (int'(share_bytes) > SBUF_BYTES)
               || (end_pos > limit);
  end

endmodule

// File: rtl/sbm_spare_walk.sv
module sbm_spare_walk #(
  parameter int SPARE_W    = 8,
  parameter int NUM_SBUF   = 8,
  parameter int SBUF_BYTES = 64,
  parameter int ADDR_W     = 13,
  parameter int SPARE_BASE = 4096,
  localparam int OFF_W     = SPARE_W + 1,
  localparam int IDX_W     = $clog2(NUM_SBUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [OFF_W-1:0]   load_off,
  input  logic [SPARE_W-1:0] share,
  input  logic               seek_en,
  input  logic               step_en,
  input  logic               clear,
  output logic [ADDR_W-1:0]  addr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SBUF - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [OFF_W-1:0] share_w;
  logic             upd;

  always_comb begin
    share_w = OFF_W'(share);
    idx_d   = idx_q;
    off_d   = off_q;
    upd     = load | clear | seek_en | step_en;
    if (load) begin
      idx_d = '0;
      off_d = load_off;
    end else if (clear) begin
      idx_d = '0;
      off_d = '0;
    end else if (seek_en) begin
      // one compare-subtract step of the clamped division
      if (off_q >= share_w && idx_q != LAST_IDX) begin
        off_d = off_q - share_w;
        idx_d = idx_q + 1'b1;
      end
    end else if (step_en) begin
      if ((off_q + 1'b1) == share_w && idx_q != LAST_IDX) begin
        off_d = '0;
        idx_d = idx_q + 1'b1;
      end else begin
        off_d = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      off_q <= '0;
    end else if (upd) begin
      idx_q <= idx_d;
      off_q <= off_d;
    end
  end

  assign addr = ADDR_W'(SPARE_BASE) + ADDR_W'(idx_q) * ADDR_W'(SBUF_BYTES)
              + ADDR_W'(off_q);

endmodule

// File: rtl/oob_addr_mapper.sv
module oob_addr_mapper
  import sbm_pkg::*;
#(
  parameter int COL_W       = 13,
  parameter int SPARE_W     = 8,
  parameter int ADDR_W      = 13,
  parameter int NUM_SBUF    = 8,
  parameter int SBUF_BYTES  = 64,
  parameter int SPARE_BASE  = 4096,
  parameter int CHUNK_BYTES = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               wr,
  input  logic               spare_only,
  input  logic [1:0]         page_sel,
  input  logic [SPARE_W-1:0] spare_size,
  input  logic [COL_W-1:0]   column,
  input  logic [COL_W-1:0]   length,
  input  logic               byte_ready,
  output logic               busy,
  output logic               byte_valid,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic               buf_we,
  output logic               done,
  output logic               err
);

  localparam int OFF_W    = SPARE_W + 1;
  localparam int SEEK_CYC = NUM_SBUF - 1;
  localparam int CNT_W    = $clog2(NUM_SBUF);

  sbm_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic [COL_W-1:0]   rem_q, rem_d;
  logic [COL_W-1:0]   page_q, page_d;
  logic [SPARE_W-1:0] share_q, share_d;
  logic               main_q, main_d;
  logic               wr_q, wr_d;
  logic               err_q, err_d;

  logic [COL_W-1:0]   g_page;
  logic [SPARE_W-1:0] g_share;
  logic [OFF_W-1:0]   g_off;
  logic               g_main, g_err;
  logic               w_load, w_seek, w_step, w_clear;
  logic [ADDR_W-1:0]  w_addr;
  logic               accept, fire;

  sbm_geom #(
    .COL_W(COL_W), .SPARE_W(SPARE_W),
    .SBUF_BYTES(SBUF_BYTES), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_geom (
    .page_sel(page_sel), .spare_size(spare_size), .column(column),
    .length(length), .spare_only(spare_only), .page_bytes(g_page),
    .share_bytes(g_share), .spare_off(g_off), .start_main(g_main),
    .cfg_err(g_err)
  );

  sbm_spare_walk #(
    .SPARE_W(SPARE_W), .NUM_SBUF(NUM_SBUF), .SBUF_BYTES(SBUF_BYTES),
    .ADDR_W(ADDR_W), .SPARE_BASE(SPARE_BASE)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .load(w_load), .load_off(g_off),
    .share(share_q), .seek_en(w_seek), .step_en(w_step), .clear(w_clear),
    .addr(w_addr)
  );

  assign accept = (state_q == ST_IDLE) && start;
  assign fire   = (state_q == ST_RUN) && byte_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    col_d   = col_q;
    rem_d   = rem_q;
    page_d  = page_q;
    share_d = share_q;
    main_d  = main_q;
    wr_d    = wr_q;
    err_d   = err_q;
    w_load  = 1'b0;
    w_seek  = 1'b0;
    w_step  = 1'b0;
    w_clear = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        wr_d    = wr;
        page_d  = g_page;
        share_d = g_share;
        col_d   = column;
        rem_d   = length;
        main_d  = g_main;
        cnt_d   = '0;
        err_d   = g_err;
        w_load  = !g_err;
        state_d = g_err ? ST_FIN : ST_SEEK;
      end
      ST_SEEK: begin
        w_seek = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(SEEK_CYC - 1))
          state_d = (rem_q == '0) ? ST_FIN : ST_RUN;
      end
      ST_RUN: if (fire) begin
        rem_d = rem_q - 1'b1;
        if (main_q) begin
          col_d = col_q + 1'b1;
          if (col_q == page_q - 1'b1) begin
            main_d  = 1'b0;
            w_clear = 1'b1;
          end
        end else begin
          w_step = 1'b1;
        end
        if (rem_q == COL_W'(1)) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      rem_q   <= '0;
      page_q  <= '0;
      share_q <= '0;
      main_q  <= 1'b0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      col_q   <= col_d;
      rem_q   <= rem_d;
      page_q  <= page_d;
      share_q <= share_d;
      main_q  <= main_d;
      wr_q    <= wr_d;
      err_q   <= err_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign byte_valid = (state_q == ST_RUN);
  assign buf_addr   = main_q ? ADDR_W'(col_q) : w_addr;
  assign buf_we     = byte_valid && wr_q;
  assign done       = (state_q == ST_FIN);
  assign err        = done && err_q;

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int ADDR_W     = 13,
  parameter int NUM_SBUF   = 8,
  parameter int SBUF_BYTES = 64,
  parameter int SPARE_BASE = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              byte_ready,
  input logic              busy,
  input logic              byte_valid,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              buf_we,
  input logic              done,
  input logic              err
);

  localparam int SPARE_END = SPARE_BASE + NUM_SBUF * SBUF_BYTES;

  // R2: an idle start makes the block busy
  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R4: spare addresses stay inside the spare buffer window
  a_r4_spare_window: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && int'(buf_addr) >= SPARE_BASE |-> int'(buf_addr) < SPARE_END);

  // R7: a stalled byte holds address and write enable
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(buf_addr) && $stable(buf_we));

  // R7: write enable only accompanies a presented byte
  a_r7_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> byte_valid);

  // R8: done is a single-cycle pulse followed by idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R9: error only with done and never with a presented byte
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !byte_valid);

endmodule

bind oob_addr_mapper sbm_checker #(
  .ADDR_W(ADDR_W), .NUM_SBUF(NUM_SBUF),
  .SBUF_BYTES(SBUF_BYTES), .SPARE_BASE(SPARE_BASE)
) u_sbm_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_ready(byte_ready),
  .busy(busy), .byte_valid(byte_valid), .buf_addr(buf_addr),
  .buf_we(buf_we), .done(done), .err(err)
);

// File: tb/oob_addr_mapper_test.sv
`timescale 1ns/1ps
module oob_addr_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, wr, spare_only, byte_ready;
  logic [1:0]  page_sel;
  logic [7:0]  spare_size;
  logic [12:0] column, length;
  logic        busy, byte_valid, buf_we, done, err;
  logic [12:0] buf_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  oob_addr_mapper uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr),
    .spare_only(spare_only), .page_sel(page_sel), .spare_size(spare_size),
    .column(column), .length(length), .byte_ready(byte_ready),
    .busy(busy), .byte_valid(byte_valid), .buf_addr(buf_addr),
    .buf_we(buf_we), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int sel, input int spare, input int col,
                                  input bit so, input int i);
    int page, chunks, sb, c, f, s;
    page   = (sel == 0) ? 512 : (sel == 1) ? 2048 : 4096;
    chunks = page / 512;
    sb     = (spare / chunks) & ~1;
    c      = col + i;
    if (!so && c < page) return c;
    f = so ? c : c - page;
    s = f / sb;
    if (s > 7) s = 7;
    return 4096 + s * 64 + (f - s * sb);
  endfunction

  // normal access; stall_at / poke_at < 0 disables that feature
  task automatic run_access(input string req, input int sel, input int spare,
                            input int col, input int len, input bit w,
                            input bit so, input int stall_at, input int poke_at);
    int  idx;
    bit  rdy, stalled, poked;
    @(negedge clk);
    page_sel = 2'(sel); spare_size = 8'(spare); column = 13'(col);
    length = 13'(len); wr = w; spare_only = so; byte_ready = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    idx = 0; stalled = 0; poked = 0;
    while (idx < len) begin
      chk(byte_valid === 1'b1, {req, " valid"}, int'(byte_valid), 1);
      chk(int'(buf_addr) == exp_addr(sel, spare, col, so, idx), {req, " addr"},
          int'(buf_addr), exp_addr(sel, spare, col, so, idx));
      chk(buf_we === w, "R7 we", int'(buf_we), int'(w));
      rdy = 1'b1;
      if (idx == stall_at && !stalled) begin rdy = 1'b0; stalled = 1; end
      if (idx == poke_at && !poked) begin
        start = 1'b1; column = 13'(col + 37); poked = 1;
      end
      byte_ready = rdy;
      @(negedge clk);
      start = 1'b0;
      if (rdy) idx++;
    end
    byte_ready = 1'b1;
    chk(done === 1'b1 && err === 1'b0 && byte_valid === 1'b0, {req, " R8 done"},
        int'({done, err, byte_valid}), 4);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, {req, " R8 idle"}, int'({busy, done}), 0);
  endtask

  task automatic run_refused(input string req, input int sel, input int spare,
                             input int col, input int len, input bit so);
    @(negedge clk);
    page_sel = 2'(sel); spare_size = 8'(spare); column = 13'(col);
    length = 13'(len); wr = 1'b1; spare_only = so; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1 && err === 1'b1 && byte_valid === 1'b0, req,
        int'({done, err, byte_valid}), 6);
    @(negedge clk);
    chk(busy === 1'b0 && err === 1'b0, {req, " idle"}, int'({busy, err}), 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr = 1'b0; spare_only = 1'b0; byte_ready = 1'b1;
    page_sel = 2'b00; spare_size = 8'd16; column = '0; length = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && byte_valid === 1'b0 && done === 1'b0 && err === 1'b0,
        "R1 reset", int'({busy, byte_valid, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 after reset", int'({busy, done}), 0);

    // R3: main area read, 512 page
    run_access("R3 main", 0, 16, 5, 6, 1'b0, 1'b0, -1, -1);
    // R4/R5: spare by column >= page, crosses buffer 0 -> 1
    run_access("R5 R4 spare col", 1, 64, 2058, 12, 1'b1, 1'b0, -1, -1);
    // R6: crossing from main into spare
    run_access("R6 cross", 0, 16, 508, 8, 1'b1, 1'b0, -1, -1);
    // R4/R5: spare-only, 4096 page, clamp to buffer 7 with leftover
    run_access("R4 R5 clamp", 2, 218, 170, 48, 1'b0, 1'b1, -1, -1);
    // R4: odd spare share rounded down to even, bytes beyond shares
    run_access("R4 rounding", 1, 70, 2108, 10, 1'b0, 1'b0, -1, -1);
    // R7: stall in the middle of a crossing access
    run_access("R7 stall", 1, 64, 2040, 12, 1'b1, 1'b0, 3, -1);
    // R2: start while busy is ignored
    run_access("R2 ignore", 0, 16, 100, 6, 1'b0, 1'b0, -1, 2);
    // R8: zero length
    run_access("R8 zero", 0, 16, 0, 0, 1'b0, 1'b0, -1, -1);
    // R9: refusals
    run_refused("R9 overflow", 0, 16, 500, 29, 1'b0);
    run_refused("R9 page code", 3, 16, 0, 4, 1'b0);
    run_refused("R9 share big", 0, 100, 0, 4, 1'b0);
    run_refused("R9 spare-only overflow", 1, 64, 60, 5, 1'b1);
    // R9 boundary: exactly at the limit is accepted
    run_access("R9 at limit", 0, 16, 520, 8, 1'b0, 1'b0, -1, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule